// File: doc/BRIEF.md
# Vector Operand Fetch and Swizzle

This block supplies one source operand to a four-lane vector shader ALU. It holds three register banks: a 96-entry constant bank, a 16-entry input bank and a 16-entry temporary bank. Each entry is 128 bits wide, made of four 32-bit lanes. A preload port fills the banks. A fetch request names a bank, an index, the operand slot being read and the instruction form. Constant reads in the designated offset slot can be relative: an address register or the loop register supplies a signed offset. The result comes out one clock later. By then it has been reordered lane by lane by an 8-bit swizzle selector and, if asked, negated.

A two-state machine tracks the output. ST_IDLE means no fresh result is on the output. ST_OUT means the vector delivered this cycle answers the previous cycle's request. The transitions are:

- GO: ST_IDLE to ST_OUT when a request arrives.
- STREAM: ST_OUT to ST_OUT on another request.
- DRAIN: ST_OUT to ST_IDLE when no request arrives.
- REST: ST_IDLE to ST_IDLE when no request arrives.

Top module: `vec_operand_fetch`

## Requirements
- R1: `valid_o` is high in exactly the cycle after a cycle with `req_i` high, and low otherwise.
- R2: With swizzle selector 0x1B and no negation, the output equals the addressed bank entry unchanged.
- R3: Output lane x (bits [31:0]) takes source lane `swz_i[7:6]`, y (bits [63:32]) takes `swz_i[5:4]`, z takes `swz_i[3:2]` and w (bits [127:96]) takes `swz_i[1:0]`. Source lane n is bits [32n+31:32n].
- R4: When `neg_i` is high, bit 31 of every lane is inverted after the swizzle.
- R5: The address selector `asel_i` picks the offset: 0 gives no offset, 1 gives `addr_x_i`, 2 gives `addr_y_i` and 3 gives `loop_i`.
- R6: An offset is applied only to constant reads (`type_i` = 0). Input reads (`type_i` = 1) and temporary reads (`type_i` = 2 or 3) use `idx_i[3:0]` and ignore the selector.
- R7: The offset slot is defined as follows. In three-operand form (`three_op_i` = 1) it is slot 3 when `inverted_i` is high and slot 2 otherwise. In two-operand form it is slot 2 when `inverted_i` is high and slot 1 otherwise. Reads from any other slot take no offset.
- R8: An offset outside the signed range -128 to 127 is replaced by zero.
- R9: The effective constant index is (`idx_i` + offset) truncated to 7 bits.
- R10: A constant read whose effective index exceeds 95 returns 0x3F800000 in every lane before negation, with no bank access.
- R11: While `req_i` stays low, `vec_o` does not change, even when the banks are written.
- R12: After reset, `valid_o` is low and `vec_o` is zero.
- R13: A preload write with `wr_en` high stores `wr_data` in the bank chosen by `wr_bank`, using the same type codes as `type_i`. Constant writes to index 96 or above are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Preload write strobe |
| wr_bank | input | 2 | Bank written: 0 constant, 1 input, 2/3 temporary |
| wr_idx | input | 7 | Preload entry index |
| wr_data | input | 128 | Preload data |
| req_i | input | 1 | Fetch request |
| type_i | input | 2 | Bank read: 0 constant, 1 input, 2/3 temporary |
| idx_i | input | 7 | Base register index |
| slot_i | input | 2 | Operand slot being read (1..3) |
| three_op_i | input | 1 | Three-operand instruction form |
| inverted_i | input | 1 | Inverted operand order |
| asel_i | input | 2 | Offset source selector |
| addr_x_i | input | 32 | Signed address register X |
| addr_y_i | input | 32 | Signed address register Y |
| loop_i | input | 32 | Signed loop counter register |
| swz_i | input | 8 | Lane swizzle selector |
| neg_i | input | 1 | Negate all lanes |
| valid_o | output | 1 | Result valid |
| vec_o | output | 128 | Fetched operand |

## Verification
All captured control sits one register stage from the ports, so a wrong captured bank code, swizzle or negate flag corrupts the very next result. A stuck state register shows up as `valid_o` out of step with requests within one cycle. A faulty offset path shows up as a neighbouring entry's data pattern, or as 1.0 lanes where bank data was expected (or the reverse). The bench therefore gives every entry and lane a unique data pattern and steps through slot, form, range and wrap corner cases.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 32;
    localparam int VEC_W  = LANES * LANE_W;
    localparam int IDX_W  = 7;
    localparam int SEL_W  = 2 * LANES;
    localparam logic [LANE_W-1:0] FP_ONE = 32'h3F80_0000;

    typedef enum logic [1:0] {
        BK_CONST = 2'd0,
        BK_INPUT = 2'd1,
        BK_TEMP  = 2'd2,
        BK_TEMP2 = 2'd3
    } bank_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } fsm_e;
endpackage

// File: rtl/ofs_index_calc.sv
module ofs_index_calc
    import ofs_pkg::*;
#(
    parameter int CONST_DEPTH = 96,
    parameter int REG_W       = 32
) (
    input  logic [1:0]        type_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [1:0]        slot_i,
    input  logic              three_op_i,
    input  logic              inverted_i,
    input  logic [1:0]        asel_i,
    input  logic [REG_W-1:0]  addr_x_i,
    input  logic [REG_W-1:0]  addr_y_i,
    input  logic [REG_W-1:0]  loop_i,
    output logic [IDX_W-1:0]  eff_idx_o,
    output logic              use_one_o
);
    logic [1:0]              slot_rel;
    logic signed [REG_W-1:0] off_raw;
    logic                    in_range;
    logic                    apply;
    logic [IDX_W-1:0]        off_bits;

    always_comb begin
        if (three_op_i) slot_rel = inverted_i ? 2'd3 : 2'd2;
        else            slot_rel = inverted_i ? 2'd2 : 2'd1;
    end

    always_comb begin
        unique case (asel_i)
            2'd1:    off_raw = addr_x_i;
            2'd2:    off_raw = addr_y_i;
            2'd3:    off_raw = loop_i;
            default: off_raw = '0;
        endcase
    end

    assign in_range  = (off_raw >= -128) && (off_raw <= 127);
    assign apply     = (bank_e'(type_i) == BK_CONST) && (asel_i != 2'd0)
                       && (slot_i == slot_rel) && in_range;
    assign off_bits  = apply ? off_raw[IDX_W-1:0] : '0;
    assign eff_idx_o = idx_i + off_bits;
    assign use_one_o = (bank_e'(type_i) == BK_CONST)
                       && (int'(eff_idx_o) >= CONST_DEPTH);
endmodule

// File: rtl/ofs_bank.sv
module ofs_bank #(
    parameter int DEPTH = 16,
    parameter int W     = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/ofs_swizzle.sv
module ofs_swizzle
    import ofs_pkg::*;
(
    input  logic [VEC_W-1:0] vec_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             neg_i,
    output logic [VEC_W-1:0] vec_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int HI = SEL_W - 1 - 2 * k;
        logic [1:0]        pick;
        logic [LANE_W-1:0] lane;
        assign pick = sel_i[HI -: 2];
        assign lane = vec_i[int'(pick) * LANE_W +: LANE_W];
        assign vec_o[k * LANE_W +: LANE_W] = {lane[LANE_W-1] ^ neg_i, lane[LANE_W-2:0]};
    end
endmodule

// File: rtl/vec_operand_fetch.sv
module vec_operand_fetch
    import ofs_pkg::*;
#(
    parameter int CONST_DEPTH = 96,
    parameter int REG_DEPTH   = 16,
    parameter int REG_W       = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_bank,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VEC_W-1:0]   wr_data,
    input  logic               req_i,
    input  logic [1:0]         type_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [1:0]         slot_i,
    input  logic               three_op_i,
    input  logic               inverted_i,
    input  logic [1:0]         asel_i,
    input  logic [REG_W-1:0]   addr_x_i,
    input  logic [REG_W-1:0]   addr_y_i,
    input  logic [REG_W-1:0]   loop_i,
    input  logic [SEL_W-1:0]   swz_i,
    input  logic               neg_i,
    output logic               valid_o,
    output logic [VEC_W-1:0]   vec_o
);
    localparam int CAW = $clog2(CONST_DEPTH);
    localparam int RAW = $clog2(REG_DEPTH);

    fsm_e             state, state_nxt;
    logic [IDX_W-1:0] eff_idx;
    logic             use_one;
    bank_e            type_q;
    logic             one_q;
    logic [SEL_W-1:0] swz_q;
    logic             neg_q;
    logic [VEC_W-1:0] c_rd, i_rd, t_rd, base;
    logic             c_we, i_we, t_we;
    logic             c_re, i_re, t_re;
    bank_e            wr_kind, rd_kind;

    ofs_index_calc #(.CONST_DEPTH(CONST_DEPTH), .REG_W(REG_W)) u_idx (
        .type_i(type_i), .idx_i(idx_i), .slot_i(slot_i),
        .three_op_i(three_op_i), .inverted_i(inverted_i), .asel_i(asel_i),
        .addr_x_i(addr_x_i), .addr_y_i(addr_y_i), .loop_i(loop_i),
        .eff_idx_o(eff_idx), .use_one_o(use_one)
    );

    assign wr_kind = bank_e'(wr_bank);
    assign rd_kind = bank_e'(type_i);
    assign c_we = wr_en && (wr_kind == BK_CONST) && (int'(wr_idx) < CONST_DEPTH);
    assign i_we = wr_en && (wr_kind == BK_INPUT);
    assign t_we = wr_en && ((wr_kind == BK_TEMP) || (wr_kind == BK_TEMP2));
    assign c_re = req_i && (rd_kind == BK_CONST) && !use_one;
    assign i_re = req_i && (rd_kind == BK_INPUT);
    assign t_re = req_i && ((rd_kind == BK_TEMP) || (rd_kind == BK_TEMP2));

    ofs_bank #(.DEPTH(CONST_DEPTH), .W(VEC_W), .AW(CAW)) u_cbank (
        .clk(clk), .rst_n(rst_n), .we(c_we), .waddr(wr_idx[CAW-1:0]), .wdata(wr_data),
        .re(c_re), .raddr(eff_idx[CAW-1:0]), .rdata(c_rd)
    );
    ofs_bank #(.DEPTH(REG_DEPTH), .W(VEC_W), .AW(RAW)) u_ibank (
        .clk(clk), .rst_n(rst_n), .we(i_we), .waddr(wr_idx[RAW-1:0]), .wdata(wr_data),
        .re(i_re), .raddr(idx_i[RAW-1:0]), .rdata(i_rd)
    );
    ofs_bank #(.DEPTH(REG_DEPTH), .W(VEC_W), .AW(RAW)) u_tbank (
        .clk(clk), .rst_n(rst_n), .we(t_we), .waddr(wr_idx[RAW-1:0]), .wdata(wr_data),
        .re(t_re), .raddr(idx_i[RAW-1:0]), .rdata(t_rd)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions GO / STREAM / DRAIN / REST
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = req_i ? ST_OUT : ST_IDLE;
            ST_OUT:  state_nxt = req_i ? ST_OUT : ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        valid_o = (state == ST_OUT);
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= BK_CONST;
            one_q  <= 1'b0;
            swz_q  <= 8'h1B;
            neg_q  <= 1'b0;
        end else if (req_i) begin
            type_q <= rd_kind;
            one_q  <= use_one;
            swz_q  <= swz_i;
            neg_q  <= neg_i;
        end
    end

    always_comb begin
        unique case (type_q)
            BK_CONST: base = one_q ? {LANES{FP_ONE}} : c_rd;
            BK_INPUT: base = i_rd;
            default:  base = t_rd;
        endcase
    end

    ofs_swizzle u_swz (.vec_i(base), .sel_i(swz_q), .neg_i(neg_q), .vec_o(vec_o));
endmodule

// File: rtl/ofs_checker.sv
module ofs_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         req_i,
    input logic [1:0]   type_i,
    input logic [6:0]   idx_i,
    input logic [1:0]   asel_i,
    input logic [7:0]   swz_i,
    input logic         neg_i,
    input logic         valid_o,
    input logic [127:0] vec_o
);
    a_r1_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    a_r1_no_valid_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);

    a_r3_broadcast_x: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && swz_i == 8'h00 && !neg_i) |=>
        (vec_o[63:32] == vec_o[31:0] && vec_o[95:64] == vec_o[31:0]
         && vec_o[127:96] == vec_o[31:0]));

    a_r10_one_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && type_i == 2'd0 && asel_i == 2'd0 && idx_i > 7'd95 && !neg_i) |=>
        (vec_o == {4{32'h3F80_0000}}));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(vec_o));
endmodule

bind vec_operand_fetch ofs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .type_i(type_i), .idx_i(idx_i),
    .asel_i(asel_i), .swz_i(swz_i), .neg_i(neg_i), .valid_o(valid_o), .vec_o(vec_o)
);

// File: tb/vec_operand_fetch_tb.sv
module vec_operand_fetch_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0;
    logic [1:0] wr_bank = 0;
    logic [6:0] wr_idx = 0;
    logic [127:0] wr_data = 0;
    logic req_i = 0;
    logic [1:0] type_i = 0;
    logic [6:0] idx_i = 0;
    logic [1:0] slot_i = 1;
    logic three_op_i = 0, inverted_i = 0;
    logic [1:0] asel_i = 0;
    logic signed [31:0] addr_x_i = 0, addr_y_i = 0, loop_i = 0;
    logic [7:0] swz_i = 8'h1B;
    logic neg_i = 0;
    logic valid_o;
    logic [127:0] vec_o;

    int checks = 0, failures = 0;
    logic [127:0] cmem [96];
    logic [127:0] imem [16];
    logic [127:0] tmem [16];
    logic [127:0] exp_q [$];
    string tag_q [$];
    logic [127:0] last_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_operand_fetch u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
        .wr_data(wr_data), .req_i(req_i), .type_i(type_i), .idx_i(idx_i), .slot_i(slot_i),
        .three_op_i(three_op_i), .inverted_i(inverted_i), .asel_i(asel_i),
        .addr_x_i(addr_x_i), .addr_y_i(addr_y_i), .loop_i(loop_i), .swz_i(swz_i),
        .neg_i(neg_i), .valid_o(valid_o), .vec_o(vec_o)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] model(input logic [1:0] ty, input logic [6:0] ix,
        input logic [1:0] sl, input bit three, input bit inv, input logic [1:0] as,
        input logic [7:0] sw, input bit ng);
        logic signed [31:0] off;
        logic [1:0] rslot;
        logic [6:0] eff;
        logic [127:0] src, res;
        rslot = three ? (inv ? 2'd3 : 2'd2) : (inv ? 2'd2 : 2'd1);
        case (as)
            2'd1: off = addr_x_i;
            2'd2: off = addr_y_i;
            2'd3: off = loop_i;
            default: off = 0;
        endcase
        if (ty != 2'd0 || sl != rslot || off < -128 || off > 127) off = 0;
        eff = ix + off[6:0];
        if (ty == 2'd0) src = (eff > 7'd95) ? {4{32'h3F80_0000}} : cmem[eff];
        else if (ty == 2'd1) src = imem[ix[3:0]];
        else src = tmem[ix[3:0]];
        for (int k = 0; k < 4; k++) begin
            int f;
            f = (sw >> (6 - 2 * k)) & 3;
            res[32*k +: 32] = src[32*f +: 32];
            if (ng) res[32*k+31] = ~res[32*k+31];
        end
        return res;
    endfunction

    task automatic preload(input logic [1:0] bk, input logic [6:0] ix, input logic [127:0] d);
        @(negedge clk);
        wr_en = 1; wr_bank = bk; wr_idx = ix; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (bk == 2'd0 && ix < 7'd96) cmem[ix] = d;
        else if (bk == 2'd1) imem[ix[3:0]] = d;
        else if (bk != 2'd0) tmem[ix[3:0]] = d;
    endtask

    task automatic issue(input string tag, input logic [1:0] ty, input logic [6:0] ix,
        input logic [1:0] sl, input bit three, input bit inv, input logic [1:0] as,
        input logic [7:0] sw, input bit ng);
        @(negedge clk);
        req_i = 1; type_i = ty; idx_i = ix; slot_i = sl; three_op_i = three;
        inverted_i = inv; asel_i = as; swz_i = sw; neg_i = ng;
        last_exp = model(ty, ix, sl, three, inv, as, sw, ng);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_i = 0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R1 actual=unexpected_valid expected=no_valid");
            end else begin
                check(tag_q.pop_front(), vec_o, exp_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R12 valid", {127'b0, valid_o}, 128'b0);
        check("R12 vec", vec_o, 128'b0);

        // R13 preload all banks with unique lane patterns
        for (int i = 0; i < 96; i++)
            preload(2'd0, 7'(i), {32'h1000_0300 | (i << 12), 32'h9000_0200 | (i << 12),
                                  32'h1000_0100 | (i << 12), 32'h1000_0000 | (i << 12)});
        for (int i = 0; i < 16; i++) begin
            preload(2'd1, 7'(i), {32'h2000_0003 | (i << 8), 32'h2000_0002 | (i << 8),
                                  32'hA000_0001 | (i << 8), 32'h2000_0000 | (i << 8)});
            preload(2'd2, 7'(i), {32'h3000_0003 | (i << 8), 32'h3000_0002 | (i << 8),
                                  32'h3000_0001 | (i << 8), 32'hB000_0000 | (i << 8)});
        end
        preload(2'd0, 7'd100, {4{32'hDEAD_BEEF}}); // R13 dropped write

        issue("R2 const identity", 2'd0, 7'd5, 2'd1, 0, 0, 2'd0, 8'h1B, 0);
        issue("R13 input bank", 2'd1, 7'd3, 2'd1, 0, 0, 2'd0, 8'h1B, 0);
        issue("R13 temp bank", 2'd2, 7'd7, 2'd1, 0, 0, 2'd0, 8'h1B, 0);
        issue("R13 temp code 3", 2'd3, 7'd9, 2'd1, 0, 0, 2'd0, 8'h1B, 0);
        issue("R3 reverse", 2'd0, 7'd20, 2'd1, 0, 0, 2'd0, 8'hE4, 0);
        issue("R3 broadcast x", 2'd1, 7'd4, 2'd1, 0, 0, 2'd0, 8'h00, 0);
        issue("R3 mixed", 2'd2, 7'd2, 2'd1, 0, 0, 2'd0, 8'h9C, 0);
        issue("R4 negate", 2'd0, 7'd6, 2'd1, 0, 0, 2'd0, 8'h1B, 1);
        issue("R4 negate swz", 2'd2, 7'd11, 2'd1, 0, 0, 2'd0, 8'h4E, 1);

        addr_x_i = 4; addr_y_i = -3; loop_i = 10;
        issue("R5 sel x", 2'd0, 7'd30, 2'd1, 0, 0, 2'd1, 8'h1B, 0);
        issue("R5 sel y", 2'd0, 7'd30, 2'd1, 0, 0, 2'd2, 8'h1B, 0);
        issue("R5 sel loop", 2'd0, 7'd30, 2'd1, 0, 0, 2'd3, 8'h1B, 0);
        issue("R5 sel none", 2'd0, 7'd30, 2'd1, 0, 0, 2'd0, 8'h1B, 0);
        issue("R6 input no offset", 2'd1, 7'd5, 2'd1, 0, 0, 2'd1, 8'h1B, 0);
        issue("R6 temp no offset", 2'd2, 7'd5, 2'd1, 0, 0, 2'd3, 8'h1B, 0);
        issue("R7 3op slot2", 2'd0, 7'd40, 2'd2, 1, 0, 2'd1, 8'h1B, 0);
        issue("R7 3op slot1", 2'd0, 7'd40, 2'd1, 1, 0, 2'd1, 8'h1B, 0);
        issue("R7 3op inv slot3", 2'd0, 7'd40, 2'd3, 1, 1, 2'd1, 8'h1B, 0);
        issue("R7 3op inv slot2", 2'd0, 7'd40, 2'd2, 1, 1, 2'd1, 8'h1B, 0);
        issue("R7 2op inv slot2", 2'd0, 7'd40, 2'd2, 0, 1, 2'd1, 8'h1B, 0);
        issue("R7 2op inv slot1", 2'd0, 7'd40, 2'd1, 0, 1, 2'd1, 8'h1B, 0);

        addr_x_i = -128; addr_y_i = 128; loop_i = -129;
        issue("R8 low edge", 2'd0, 7'd90, 2'd1, 0, 0, 2'd1, 8'h1B, 0);
        issue("R8 over 127", 2'd0, 7'd10, 2'd1, 0, 0, 2'd2, 8'h1B, 0);
        issue("R8 under -128", 2'd0, 7'd10, 2'd1, 0, 0, 2'd3, 8'h1B, 0);
        addr_x_i = 127; addr_y_i = -5;
        issue("R9 wrap up", 2'd0, 7'd1, 2'd1, 0, 0, 2'd1, 8'h1B, 0);
        issue("R9 wrap down", 2'd0, 7'd2, 2'd1, 0, 0, 2'd2, 8'h1B, 0);
        issue("R10 idx 95", 2'd0, 7'd95, 2'd1, 0, 0, 2'd0, 8'h1B, 0);
        issue("R10 idx 96", 2'd0, 7'd96, 2'd1, 0, 0, 2'd0, 8'h1B, 0);
        issue("R10 idx 127 neg", 2'd0, 7'd127, 2'd1, 0, 0, 2'd0, 8'hE4, 1);
        issue("R10 idx 100 after drop", 2'd0, 7'd100, 2'd1, 0, 0, 2'd0, 8'h1B, 0);

        // back-to-back stream
        @(negedge clk);
        req_i = 1; type_i = 2'd0; idx_i = 7'd12; slot_i = 2'd1; asel_i = 2'd0;
        swz_i = 8'h1B; neg_i = 0; three_op_i = 0; inverted_i = 0;
        exp_q.push_back(model(2'd0, 7'd12, 2'd1, 0, 0, 2'd0, 8'h1B, 0));
        tag_q.push_back("R1 stream a");
        @(negedge clk);
        idx_i = 7'd13;
        last_exp = model(2'd0, 7'd13, 2'd1, 0, 0, 2'd0, 8'h1B, 0);
        exp_q.push_back(last_exp);
        tag_q.push_back("R1 stream b");
        @(negedge clk);
        req_i = 0;

        // R11 hold while the read entry is rewritten
        @(negedge clk);
        wr_en = 1; wr_bank = 2'd0; wr_idx = 7'd13; wr_data = {4{32'h5555_AAAA}};
        @(negedge clk);
        wr_en = 0;
        repeat (2) @(negedge clk);
        check("R11 hold vec", vec_o, last_exp);
        check("R11 valid low", {127'b0, valid_o}, 128'b0);
        check("R1 all answered", 128'(exp_q.size()), 128'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule